// File: doc/BRIEF.md
# Four-beat burst address sequencer

This block produces the internal word address of a synchronous memory that delivers four data beats for each address it is given. A load cycle captures an external address and starts a burst. Each later advance cycle steps the two low address bits to the next beat, while the upper bits stay where they were. The order of the beats comes from a mode input that is tied off for the whole run. In linear mode the low bits count up and wrap inside the aligned four-word group. In interleaved mode the low bits are the starting low bits XORed with a beat count.

A load taken while the chip is not selected ends the burst in progress. An active-low clock enable freezes the whole block. The array, the data path and the byte-write logic sit in other blocks, which use `burst_addr` as the address of the current beat and `burst_active` to tell whether a burst is open.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `burst_addr` is 0 and `burst_active` is 0.
- R2: A clock edge with `clk_en_n`=0, `adv_ld`=0 and `chip_sel`=1 makes `burst_addr` equal to the sampled `addr_in` and sets `burst_active` to 1 after that edge.
- R3: In linear mode (`order_ilv`=0), the k-th advance after a load with start low bits s gives low bits (s+k) mod 4. Bits [ADDR_W-1:2] keep their loaded value and `addr_in` is ignored.
- R4: In interleaved mode (`order_ilv`=1), the k-th advance gives low bits s XOR (k mod 4), with the upper bits unchanged.
- R5: The fourth advance of a burst returns `burst_addr` to the loaded address, and the sequence then repeats. The burst never leaves its aligned group.
- R6: A clock edge with `clk_en_n`=0, `adv_ld`=0 and `chip_sel`=0 clears `burst_active` and leaves `burst_addr` unchanged.
- R7: An advance (`adv_ld`=1) taken while `burst_active` is 0 leaves `burst_addr` unchanged and `burst_active` at 0.
- R8: A clock edge with `clk_en_n`=1 changes neither output, whatever the other inputs are. A burst then continues from the same beat once the clock enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load (or end, if not selected) |
| chip_sel | input | 1 | Combined chip-select qualifier, active high |
| order_ilv | input | 1 | Static burst order: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | External word address |
| burst_addr | output | ADDR_W | Address of the current beat |
| burst_active | output | 1 | A burst is open |

## Verification
The bench builds the block with ADDR_W = 6. With that width every one of the 64 start addresses can be loaded in both burst orders. Each address is followed through five advances, which covers all four start offsets and the wrap back to the start. The bench also checks that the upper bits stay fixed under an inverted `addr_in`. Every burst also includes a frozen cycle, a deselecting load and an advance with no burst open, so R6 to R8 are checked from every start position.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_END  = 2'd2,
        CMD_STEP = 2'd3
    } seq_cmd_e;
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
    import burst_seq_pkg::*;
(
    input  logic     clk_en_n,
    input  logic     adv_ld,
    input  logic     chip_sel,
    input  logic     active,
    output seq_cmd_e cmd
);
    always_comb begin
        if (clk_en_n)
            cmd = CMD_HOLD;
        else if (!adv_ld)
            cmd = chip_sel ? CMD_LOAD : CMD_END;
        else
            cmd = active ? CMD_STEP : CMD_HOLD;
    end
endmodule

// File: rtl/burst_lo_gen.sv
module burst_lo_gen
    import burst_seq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_ilv,
    output logic [BEAT_W-1:0] lo
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Both orders wrap inside the aligned group: the sum is taken modulo 2**BEAT_W.
    assign lin_lo = start_lo + beat;
    assign ilv_lo = start_lo ^ beat;
    assign lo     = order_ilv ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              adv_ld,
    input  logic              chip_sel,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              burst_active
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [BEAT_W-1:0]  start_lo;
        logic [BEAT_W-1:0]  beat;
        logic [BEAT_W-1:0]  lo;
        logic               active;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    seq_cmd_e          cmd;
    logic [BEAT_W-1:0] beat_nx;
    logic [BEAT_W-1:0] lo_nx;

    burst_cmd_dec u_dec (
        .clk_en_n (clk_en_n),
        .adv_ld   (adv_ld),
        .chip_sel (chip_sel),
        .active   (st_q.active),
        .cmd      (cmd)
    );

    assign beat_nx = st_q.beat + 1'b1;

    burst_lo_gen u_lo (
        .start_lo  (st_q.start_lo),
        .beat      (beat_nx),
        .order_ilv (order_ilv),
        .lo        (lo_nx)
    );

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.upper    = addr_in[ADDR_W-1:BEAT_W];
                st_d.start_lo = addr_in[BEAT_W-1:0];
                st_d.lo       = addr_in[BEAT_W-1:0];
                st_d.beat     = '0;
                st_d.active   = 1'b1;
            end
            CMD_END: begin
                st_d.active = 1'b0;
            end
            CMD_STEP: begin
                st_d.beat = beat_nx;
                st_d.lo   = lo_nx;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign burst_addr   = {st_q.upper, st_q.lo};
    assign burst_active = st_q.active;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic              chip_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] burst_addr,
    input logic              burst_active
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (burst_addr == '0) && !burst_active);

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && chip_sel) |=>
            (burst_addr == $past(addr_in)) && burst_active);

    assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld) |=> $stable(burst_addr[ADDR_W-1:2]));

    assert_lsb_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && burst_active) |=>
            (burst_addr[0] != $past(burst_addr[0])) && burst_active);

    assert_deselect_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && !chip_sel) |=>
            !burst_active && $stable(burst_addr));

    assert_idle_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && !burst_active) |=>
            !burst_active && $stable(burst_addr));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(burst_addr) && $stable(burst_active));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en_n     (clk_en_n),
    .adv_ld       (adv_ld),
    .chip_sel     (chip_sel),
    .addr_in      (addr_in),
    .burst_addr   (burst_addr),
    .burst_active (burst_active)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          adv_ld = 1'b1;
    logic          chip_sel = 1'b0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] burst_addr;
    logic          burst_active;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en_n     (clk_en_n),
        .adv_ld       (adv_ld),
        .chip_sel     (chip_sel),
        .order_ilv    (order_ilv),
        .addr_in      (addr_in),
        .burst_addr   (burst_addr),
        .burst_active (burst_active)
    );

    task automatic check(input string req, input logic [AW-1:0] exp_addr,
                         input logic exp_act);
        vectors++;
        if (burst_addr !== exp_addr || burst_active !== exp_act) begin
            fails++;
            $display("FAIL %s: addr=%0d active=%0b expected addr=%0d active=%0b",
                     req, burst_addr, burst_active, exp_addr, exp_act);
        end
    endtask

    task automatic cycle(input logic cen_n, input logic adv, input logic sel,
                         input logic [AW-1:0] a);
        clk_en_n = cen_n;
        adv_ld   = adv;
        chip_sel = sel;
        addr_in  = a;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] s,
                                                  input int k, input bit ilv);
        int lo;
        lo = ilv ? ((s % 4) ^ (k % 4)) : (((s % 4) + k) % 4);
        return AW'((s / 4) * 4 + lo);
    endfunction

    initial begin
        #1;
        check("R1", '0, 1'b0);
        @(posedge clk); #1;
        check("R1", '0, 1'b0);
        rst_n = 1'b1;
        cycle(1'b0, 1'b1, 1'b0, 6'h3F);
        check("R1", '0, 1'b0);
        cycle(1'b0, 1'b1, 1'b1, 6'h15);
        check("R7", '0, 1'b0);

        for (int ord = 0; ord < 2; ord++) begin
            order_ilv = ord[0];
            for (int s = 0; s < 64; s++) begin
                cycle(1'b0, 1'b0, 1'b1, AW'(s));
                check("R2", AW'(s), 1'b1);
                for (int k = 1; k <= 5; k++) begin
                    cycle(1'b0, 1'b1, 1'b1, ~AW'(s));
                    check(k == 4 ? "R5" : (ord == 1 ? "R4" : "R3"),
                          expect_addr(AW'(s), k, ord[0]), 1'b1);
                    if (k == 2) begin
                        cycle(1'b1, 1'b0, 1'b1, ~AW'(s));
                        check("R8", expect_addr(AW'(s), k, ord[0]), 1'b1);
                    end
                end
                cycle(1'b0, 1'b0, 1'b0, ~AW'(s));
                check("R6", expect_addr(AW'(s), 5, ord[0]), 1'b0);
                cycle(1'b0, 1'b1, 1'b1, ~AW'(s));
                check("R7", expect_addr(AW'(s), 5, ord[0]), 1'b0);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule